// File: doc/BRIEF.md
# Dual-Oscillator CPU Clock Switch Controller

This controller decides which of two oscillators paces the CPU: an on-die ring oscillator or an external X1 oscillator. Both oscillators appear as one-cycle tick strobes in a single system clock domain. The controller passes a CPU clock-enable tick stream to its output. After reset the ring oscillator is the default source. The first 17 ring ticks after release are withheld, so the CPU sees no clock until that startup gap has passed.

Software can move the CPU to X1 once the X1 stabilization flag is up. It writes a select control. The move completes on the next tick of X1, and a status output then reports the active source. Software can also stop or restart each oscillator. A stop request is honoured only for the oscillator that is not pacing the CPU. For the ring oscillator, a configuration input must also mark it as stoppable.

Top module: `cpu_clk_switch`

## Requirements
- R1: While rst_n is low, ring_run, x1_run, src_is_x1 and cpu_clk_en are all 0, whatever the tick inputs do.
- R2: On the first rising clock edge after rst_n goes high, both ring_run and x1_run become 1.
- R3: Once both oscillators run, the first 17 ring ticks give no cpu_clk_en. From the 18th ring tick onward, each ring tick raises cpu_clk_en in that same cycle, however many idle cycles separate the ticks.
- R4: A select write with sel_x1=1 is ignored unless three conditions hold: x1_stable=1, x1_run=1 and the 17-tick startup gap is over. An ignored write leaves src_is_x1 at 0, even after later X1 ticks.
- R5: After an accepted switch to X1, cpu_clk_en keeps following ring ticks until the next X1 tick. That X1 tick is not forwarded, and src_is_x1 goes to 1 on the same edge. After that, cpu_clk_en follows X1 ticks only.
- R6: A ring stop write (ring_we=1, ring_stop=1) takes effect only when three conditions hold: src_is_x1=1, no switch back to the ring is pending, and ring_stoppable=1. It then clears ring_run on the next edge. Otherwise it is ignored.
- R7: An X1 stop write (x1_we=1, x1_stop=1) takes effect only when src_is_x1=0 and no switch to X1 is pending. It then clears x1_run on the next edge. Otherwise it is ignored.
- R8: A stop-control write with the value 0 restarts that oscillator on the next edge, with no condition.
- R9: A select write with sel_x1=0 is accepted only while ring_run=1. After it, src_is_x1 falls on the edge of the next ring tick, and that ring tick is not forwarded. An ignored write leaves the CPU on X1.
- R10: cpu_clk_en is never raised except by a tick of the active source while that source is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_tick | input | 1 | Ring oscillator tick strobe |
| x1_tick | input | 1 | X1 oscillator tick strobe |
| x1_stable | input | 1 | X1 stabilization time has elapsed |
| ring_stoppable | input | 1 | Configuration: ring oscillator may be stopped by software |
| sel_we | input | 1 | Write strobe for the main-clock select control |
| sel_x1 | input | 1 | Select data: 1 requests X1, 0 requests the ring oscillator |
| ring_we | input | 1 | Write strobe for the ring stop control |
| ring_stop | input | 1 | Ring stop data: 1 stops, 0 restarts |
| x1_we | input | 1 | Write strobe for the X1 stop control |
| x1_stop | input | 1 | X1 stop data: 1 stops, 0 restarts |
| cpu_clk_en | output | 1 | CPU clock-enable tick stream |
| src_is_x1 | output | 1 | Active source status: 1 = X1, 0 = ring |
| ring_run | output | 1 | Ring oscillator run enable |
| x1_run | output | 1 | X1 oscillator run enable |

## Verification
A wrong startup count shows on the first ring tick that should or should not be forwarded: tick 17 or tick 18 after release. A status bit out of step with the select control shows within one tick of either source, as a tick forwarded from the wrong oscillator or a missing one. A badly guarded stop request shows on the next edge as a dropped run enable on the active source, and cpu_clk_en then stays silent. The bench sweeps the startup gap over several tick spacings and tries every guarded write in each source state.

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch #(
  parameter int unsigned STARTUP_TICKS = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_tick,
  input  logic x1_tick,
  input  logic x1_stable,
  input  logic ring_stoppable,
  input  logic sel_we,
  input  logic sel_x1,
  input  logic ring_we,
  input  logic ring_stop,
  input  logic x1_we,
  input  logic x1_stop,
  output logic cpu_clk_en,
  output logic src_is_x1,
  output logic ring_run,
  output logic x1_run
);
  localparam int unsigned CW = $clog2(STARTUP_TICKS + 1);

  logic          started_q, ring_off_q, x1_off_q, sel_q, stat_q;
  logic [CW-1:0] boot_cnt_q;

  wire boot_done = (boot_cnt_q == CW'(STARTUP_TICKS));

  assign ring_run  = started_q & ~ring_off_q;
  assign x1_run    = started_q & ~x1_off_q;
  assign src_is_x1 = stat_q;

  wire ring_t = ring_tick & ring_run;
  wire x1_t   = x1_tick & x1_run;

  wire to_x1   = sel_we & sel_x1 & boot_done & x1_stable & x1_run;
  wire to_ring = sel_we & ~sel_x1 & ring_run;

  wire ring_stop_ok = ring_we & ring_stop & stat_q & sel_q & ring_stoppable & ~to_ring;
  wire x1_stop_ok   = x1_we & x1_stop & ~stat_q & ~sel_q & ~to_x1;

  assign cpu_clk_en = boot_done & (stat_q ? x1_t : ring_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q  <= 1'b0;
      ring_off_q <= 1'b0;
      x1_off_q   <= 1'b0;
      sel_q      <= 1'b0;
      stat_q     <= 1'b0;
      boot_cnt_q <= '0;
    end else begin
      started_q <= 1'b1;
      if (!boot_done && ring_t) boot_cnt_q <= boot_cnt_q + 1'b1;

      if (to_x1)        sel_q <= 1'b1;
      else if (to_ring) sel_q <= 1'b0;

      if (sel_q && !stat_q && x1_t)        stat_q <= 1'b1;
      else if (!sel_q && stat_q && ring_t) stat_q <= 1'b0;

      if (ring_stop_ok)             ring_off_q <= 1'b1;
      else if (ring_we && !ring_stop) ring_off_q <= 1'b0;

      if (x1_stop_ok)               x1_off_q <= 1'b1;
      else if (x1_we && !x1_stop)   x1_off_q <= 1'b0;
    end
  end

  AST_SWITCH_ON_X1_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_is_x1) |-> $past(x1_tick && x1_run)); // R5
  AST_SWITCH_ON_RING_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_is_x1) |-> $past(ring_tick && ring_run)); // R9
  AST_RING_STOP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_run) |-> $past(src_is_x1) && $past(ring_stoppable)); // R6
  AST_X1_STOP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(x1_run) |-> !$past(src_is_x1)); // R7
  AST_EN_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (src_is_x1 ? (x1_tick && x1_run) : (ring_tick && ring_run))); // R10
  AST_ACTIVE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en || src_is_x1) |-> (src_is_x1 ? x1_run : ring_run)); // R10
endmodule

// File: tb/tb_cpu_clk_switch.sv
`timescale 1ns/1ps
module tb_cpu_clk_switch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_tick = 0, x1_tick = 0, x1_stable = 0, ring_stoppable = 0;
  logic sel_we = 0, sel_x1 = 0, ring_we = 0, ring_stop = 0, x1_we = 0, x1_stop = 0;
  logic cpu_clk_en, src_is_x1, ring_run, x1_run;
  int   checks = 0, fails = 0;
  bit   done = 0;
  logic en;

  always #2 clk = ~clk;

  cpu_clk_switch dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one system cycle: drive after negedge, capture cpu_clk_en mid-cycle, end after posedge
  task automatic step(input logic r, input logic x, input logic sw = 0, input logic sv = 0,
                      input logic rw = 0, input logic rv = 0, input logic xw = 0, input logic xv = 0);
    @(negedge clk);
    ring_tick = r; x1_tick = x; sel_we = sw; sel_x1 = sv;
    ring_we = rw; ring_stop = rv; x1_we = xw; x1_stop = xv;
    #1 en = cpu_clk_en;
    @(posedge clk); #0.5;
    ring_tick = 0; x1_tick = 0; sel_we = 0; ring_we = 0; x1_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) begin
      step(1, 1);
      chk("R1 en in reset", en, 1'b0);
    end
    chk("R1 ring_run", ring_run, 1'b0);
    chk("R1 x1_run", x1_run, 1'b0);
    chk("R1 status", src_is_x1, 1'b0);
    @(negedge clk); rst_n = 1;
    step(0, 0);
    chk("R2 ring_run", ring_run, 1'b1);
    chk("R2 x1_run", x1_run, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R3: startup gap swept over tick spacings, with stray X1 ticks in between
    for (int gap = 0; gap < 4; gap++) begin
      do_reset();
      for (int t = 1; t <= 22; t++) begin
        step(1, 0);
        chk($sformatf("R3 tick %0d gap %0d", t, gap), en, (t > 17));
        for (int g = 0; g < gap; g++) begin
          step(0, 1);
          chk("R10 x1 tick while ring active", en, 1'b0);
        end
      end
    end

    // R4: switch refused during the startup gap even with X1 stable
    do_reset();
    x1_stable = 1;
    step(0, 0, 1, 1);
    step(0, 1);
    chk("R4 refused during startup", src_is_x1, 1'b0);
    for (int t = 0; t < 17; t++) step(1, 0);
    // R4: refused before stabilization
    x1_stable = 0;
    step(0, 0, 1, 1);
    step(0, 1);
    chk("R4 refused before stable", src_is_x1, 1'b0);
    step(1, 0);
    chk("R4 still ring clocked", en, 1'b1);
    // R6: ring stop refused while ring active
    ring_stoppable = 1;
    step(0, 0, 0, 0, 1, 1);
    chk("R6 ring stop refused on ring", ring_run, 1'b1);
    // R5: accepted switch
    x1_stable = 1;
    step(0, 0, 1, 1);
    // R6: ring stop refused while switch to X1 still pending
    step(0, 0, 0, 0, 1, 1);
    chk("R6 ring stop refused while pending", ring_run, 1'b1);
    // R7: X1 stop refused while switch pending
    step(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R7 x1 stop refused while pending", x1_run, 1'b1);
    step(1, 0);
    chk("R5 ring still forwarded while pending", en, 1'b1);
    chk("R5 status still 0", src_is_x1, 1'b0);
    step(0, 1);
    chk("R5 switching x1 tick not forwarded", en, 1'b0);
    chk("R5 status 1", src_is_x1, 1'b1);
    step(0, 1);
    chk("R5 x1 tick forwarded", en, 1'b1);
    step(1, 0);
    chk("R10 ring tick ignored on x1", en, 1'b0);
    // R7: X1 stop refused while X1 active
    step(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R7 x1 stop refused on x1", x1_run, 1'b1);
    // R6: not stoppable -> refused; stoppable -> accepted
    ring_stoppable = 0;
    step(0, 0, 0, 0, 1, 1);
    chk("R6 ring stop refused not stoppable", ring_run, 1'b1);
    ring_stoppable = 1;
    step(0, 0, 0, 0, 1, 1);
    chk("R6 ring stopped", ring_run, 1'b0);
    // R9: switch back refused while ring stopped
    step(0, 0, 1, 0);
    step(1, 0);
    step(0, 1);
    chk("R9 refused, x1 still forwarded", en, 1'b1);
    chk("R9 status stays 1", src_is_x1, 1'b1);
    // R8: restart ring
    step(0, 0, 0, 0, 1, 0);
    chk("R8 ring restarted", ring_run, 1'b1);
    // R9: switch back
    step(0, 0, 1, 0);
    step(0, 1);
    chk("R9 x1 forwarded while pending", en, 1'b1);
    step(1, 0);
    chk("R9 switching ring tick not forwarded", en, 1'b0);
    chk("R9 status 0", src_is_x1, 1'b0);
    step(1, 0);
    chk("R9 ring forwarded", en, 1'b1);
    // R7: X1 stop accepted on ring
    step(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R7 x1 stopped", x1_run, 1'b0);
    step(0, 1);
    chk("R10 stopped x1 tick silent", en, 1'b0);
    // R4: switch refused while X1 stopped
    step(0, 0, 1, 1);
    step(0, 1);
    chk("R4 refused x1 stopped", src_is_x1, 1'b0);
    step(1, 0);
    chk("R4 ring still forwarded", en, 1'b1);
    // R8: restart X1
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 x1 restarted", x1_run, 1'b1);
    step(0, 1);
    chk("R4 no stale request after restart", src_is_x1, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule